// File: doc/BRIEF.md
# Stop-Clock Frequency Switch Sequencer

This block runs on a fast reference clock and generates the clock of a downstream processor through a programmable divider with an output gate. The processor's input clock may only drift slowly during normal operation. Any step change in frequency is therefore wrapped in a stop-clock handshake. The sequencer pulls an active-low stop request and waits for the processor's stop-grant acknowledge. It then loads the new divider on a low phase of the output clock and lets the new clock run for a settling interval. Only after that does it release the request.

A request may also ask for deep sleep. After the handshake, and after any retune that was asked for in the same request, the output clock is gated off and held low until a wake pulse arrives. The sequencer then re-enables the clock, lets it settle, and releases the stop request. Requests that arrive during a sequence are held in a single slot and served once the sequencer is idle again. If the acknowledge never comes, a timeout flags an error and leaves the stop request asserted, without touching the divider.

Top module: `stpclk_freq_seq`

## Requirements
- R1: After reset, stop_n is 1 and busy, done and err are 0. pclk runs with a high phase of DIV_RST and a low phase of DIV_RST reference cycles.
- R2: While stop_n is 1, every full pclk period has the same length, 2×(current divider) reference cycles.
- R3: A command (cmd_valid with cmd_set_div or cmd_sleep) accepted while idle drives stop_n to 0 within 2 cycles. The pclk period stays unchanged until grant_ack has been seen at 1.
- R4: After the grant, the pclk period becomes 2×cmd_div reference cycles, with a cmd_div of 0 treated as 1. The new setting takes effect only at the end of a low phase of pclk.
- R5: After a retune, stop_n returns to 1 only after at least 8 full periods of the new pclk.
- R6: After stop_n returns to 1, the block waits for grant_ack to fall. It then pulses done for one cycle and drops busy.
- R7: A command accepted while busy is held, and the most recent one is served after the current sequence completes.
- R8: A command with cmd_sleep set holds pclk at 0 and keeps stop_n at 0 after the grant and after any retune it asks for, until wake_req.
- R9: After wake_req in the sleep state, stop_n returns to 1 only after at least 8 full pclk periods have run.
- R10: wake_req outside the sleep state has no effect: stop_n stays 1 and busy stays 0 while idle.
- R11: If grant_ack stays 0 for TMO_CYC cycles after the stop request, err rises. stop_n stays 0 and the pclk period is unchanged. err clears when grant_ack arrives, and the sequence then completes.
- R12: cmd_valid with both cmd_set_div and cmd_sleep at 0 is ignored: no stop request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_set_div | input | 1 | Command carries a new divider |
| cmd_div | input | DIV_W | New half-period in reference cycles (0 means 1) |
| cmd_sleep | input | 1 | Command asks for clock-gated sleep |
| wake_req | input | 1 | One-cycle pulse ending sleep |
| grant_ack | input | 1 | Stop-grant acknowledge level from the processor |
| pclk | output | 1 | Divided, gated processor clock |
| stop_n | output | 1 | Active-low stop-clock request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| err | output | 1 | Grant timeout flag |

## Verification
The hardest situations to reach are the two settle windows. The first runs from the moment a new divider takes hold to the release of the stop request. The second runs from the wake pulse to the release. Both are defined by counting pclk edges rather than reference cycles, so they are only visible indirectly. The stimulus drives sequences with delayed grants, a back-to-back pair in which the second command lands mid-sequence, a combined retune-and-sleep request, and a grant that is withheld until the timeout. A monitor measures each pclk period and counts the full periods of unchanged length before every rising edge of stop_n. These are compared with the divider queued by the driver.

// File: rtl/fsc_pkg.sv
// Package: shared state type of the stop-clock frequency switch sequencer.
package fsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_STOP,
        ST_WAIT_GRANT,
        ST_RETUNE,
        ST_SETTLE,
        ST_GATED,
        ST_WAKE_SETTLE,
        ST_RELEASE
    } seq_state_e;
endpackage

// File: rtl/fsc_clkdiv.sv
// Glitch-free clock divider with output gate.
// pclk is high for div cycles and low for div cycles. The divider setting and
// the gate are sampled only at the end of a low phase, so the output never
// carries a runt pulse. A divider target of 0 is treated as 1.
// Assumes div_tgt and gate_tgt are held stable by the controller.
module fsc_clkdiv #(
    parameter int DIV_W   = 4,
    parameter int DIV_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_tgt,
    input  logic             gate_tgt,
    input  logic             load_req,
    output logic             pclk,
    output logic [DIV_W-1:0] div_cur,
    output logic             gate_cur,
    output logic             rise_p,
    output logic             load_ack
);
    localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);
    localparam logic [DIV_W-1:0] RST_HALF = DIV_W'(DIV_RST);

    logic [DIV_W-1:0] ph_cnt;
    logic [DIV_W-1:0] div_act;
    logic [DIV_W-1:0] div_eff;
    logic             pclk_q;
    logic             gate_q;
    logic             phase_end;

    // Clamp a zero target to the shortest legal half period.
    always_comb div_eff = (div_tgt == '0) ? ONE : div_tgt;

    // Detect the last reference cycle of the current half period.
    always_comb phase_end = (ph_cnt >= (div_act - ONE));

    // Advance the phase counter and load new settings at low-phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt   <= '0;
            div_act  <= RST_HALF;
            pclk_q   <= 1'b0;
            gate_q   <= 1'b0;
            rise_p   <= 1'b0;
            load_ack <= 1'b0;
        end else begin
            rise_p   <= 1'b0;
            load_ack <= 1'b0;
            if (phase_end) begin
                ph_cnt <= '0;
                if (pclk_q) begin
                    pclk_q <= 1'b0;
                end else begin
                    div_act  <= div_eff;
                    gate_q   <= gate_tgt;
                    pclk_q   <= !gate_tgt;
                    rise_p   <= !gate_tgt;
                    load_ack <= load_req;
                end
            end else begin
                ph_cnt <= ph_cnt + ONE;
            end
        end
    end

    assign pclk     = pclk_q;
    assign div_cur  = div_act;
    assign gate_cur = gate_q;
endmodule

// File: rtl/fsc_settle.sv
// Settle counter: counts rising edges of the processor clock.
// Cleared by clr (which has priority over a coinciding edge) and saturates at
// CNT_MAX, so a long settle never wraps.
module fsc_settle #(
    parameter int CNT_MAX = 9,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rise,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    // Count processor clock edges since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (rise && (cnt != LIMIT)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fsc_ctrl.sv
// Sequencing controller for the stop-clock handshake.
// Holds one pending command. Walks stop request, grant wait, retune, settle,
// optional gated sleep, wake settle and release. Flags a grant timeout.
// Assumes grant_ack is a clean synchronous level.
module fsc_ctrl
    import fsc_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int DIV_RST    = 2,
    parameter int SETTLE_CYC = 8,
    parameter int TMO_CYC    = 64,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_set_div,
    input  logic [DIV_W-1:0] cmd_div,
    input  logic             cmd_sleep,
    input  logic             wake_req,
    input  logic             grant,
    input  logic [CNT_W-1:0] settle_cnt,
    input  logic             load_ack,
    output seq_state_e       state,
    output logic [DIV_W-1:0] div_tgt,
    output logic             gate_tgt,
    output logic             load_req,
    output logic             settle_clr,
    output logic             stop_n,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_N = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] WAKE_N   = CNT_W'(SETTLE_CYC + 1);

    logic             pend_v;
    logic             pend_set;
    logic [DIV_W-1:0] pend_div;
    logic             pend_sleep;
    logic             cur_set;
    logic [DIV_W-1:0] cur_div;
    logic             cur_sleep;
    logic [TMO_W-1:0] tmo_cnt;
    logic             cmd_take;
    logic             launch;

    // Accept only commands that ask for something.
    always_comb cmd_take = cmd_valid && (cmd_set_div || cmd_sleep);
    // Start a held command once idle.
    always_comb launch = (state == ST_IDLE) && pend_v;

    // Hold the most recent command until the sequencer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_set   <= 1'b0;
            pend_div   <= '0;
            pend_sleep <= 1'b0;
        end else if (cmd_take) begin
            pend_v     <= 1'b1;
            pend_set   <= cmd_set_div;
            pend_div   <= cmd_div;
            pend_sleep <= cmd_sleep;
        end else if (launch) begin
            pend_v <= 1'b0;
        end
    end

    // Main sequence: handshake, retune, settle, sleep, wake, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_set   <= 1'b0;
            cur_div   <= '0;
            cur_sleep <= 1'b0;
            div_tgt   <= DIV_W'(DIV_RST);
            gate_tgt  <= 1'b0;
            load_req  <= 1'b0;
            tmo_cnt   <= '0;
            err       <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        cur_set   <= pend_set;
                        cur_div   <= pend_div;
                        cur_sleep <= pend_sleep;
                        state     <= ST_REQ_STOP;
                    end
                end
                ST_REQ_STOP: begin
                    tmo_cnt <= '0;
                    state   <= ST_WAIT_GRANT;
                end
                ST_WAIT_GRANT: begin
                    if (grant) begin
                        err <= 1'b0;
                        if (cur_set) begin
                            div_tgt  <= cur_div;
                            load_req <= 1'b1;
                            state    <= ST_RETUNE;
                        end else begin
                            gate_tgt <= 1'b1;
                            state    <= ST_GATED;
                        end
                    end else if (tmo_cnt >= TMO_LAST) begin
                        err <= 1'b1;
                    end else begin
                        tmo_cnt <= tmo_cnt + TMO_W'(1);
                    end
                end
                ST_RETUNE: begin
                    if (load_ack) begin
                        load_req <= 1'b0;
                        state    <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt >= SETTLE_N) begin
                        if (cur_sleep) begin
                            gate_tgt <= 1'b1;
                            state    <= ST_GATED;
                        end else begin
                            state <= ST_RELEASE;
                        end
                    end
                end
                ST_GATED: begin
                    if (wake_req) begin
                        gate_tgt <= 1'b0;
                        state    <= ST_WAKE_SETTLE;
                    end
                end
                ST_WAKE_SETTLE: begin
                    if (settle_cnt >= WAKE_N) begin
                        state <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (!grant) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Clear the settle count on a divider load and all through sleep.
    always_comb settle_clr = load_ack || (state == ST_GATED);
    // Stop request is released only when idle or releasing.
    always_comb stop_n = (state == ST_IDLE) || (state == ST_RELEASE);
    // Any non-idle state is a sequence in progress.
    always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/stpclk_freq_seq.sv
// Top: stop-clock frequency switch sequencer.
// Connects the controller, the glitch-free divider and the settle counter.
// Assumes all inputs are synchronous to clk_ref.
module stpclk_freq_seq #(
    parameter int DIV_W      = 4,
    parameter int DIV_RST    = 2,
    parameter int SETTLE_CYC = 8,
    parameter int TMO_CYC    = 64
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_set_div,
    input  logic [DIV_W-1:0] cmd_div,
    input  logic             cmd_sleep,
    input  logic             wake_req,
    input  logic             grant_ack,
    output logic             pclk,
    output logic             stop_n,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import fsc_pkg::*;

    localparam int CNT_MAX = SETTLE_CYC + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic [DIV_W-1:0] div_tgt;
    logic [DIV_W-1:0] div_cur;
    logic             gate_tgt;
    logic             gate_cur;
    logic             load_req;
    logic             load_ack;
    logic             rise_p;
    logic             settle_clr;
    logic [CNT_W-1:0] settle_cnt;

    fsc_ctrl #(
        .DIV_W(DIV_W), .DIV_RST(DIV_RST), .SETTLE_CYC(SETTLE_CYC),
        .TMO_CYC(TMO_CYC), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk(clk_ref), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_set_div(cmd_set_div), .cmd_div(cmd_div),
        .cmd_sleep(cmd_sleep), .wake_req(wake_req), .grant(grant_ack),
        .settle_cnt(settle_cnt), .load_ack(load_ack),
        .state(state), .div_tgt(div_tgt), .gate_tgt(gate_tgt),
        .load_req(load_req), .settle_clr(settle_clr), .stop_n(stop_n),
        .busy(busy), .done(done), .err(err)
    );

    fsc_clkdiv #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) div_i (
        .clk(clk_ref), .rst_n(rst_n),
        .div_tgt(div_tgt), .gate_tgt(gate_tgt), .load_req(load_req),
        .pclk(pclk), .div_cur(div_cur), .gate_cur(gate_cur),
        .rise_p(rise_p), .load_ack(load_ack)
    );

    fsc_settle #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) settle_i (
        .clk(clk_ref), .rst_n(rst_n),
        .clr(settle_clr), .rise(rise_p), .cnt(settle_cnt)
    );
endmodule

// File: rtl/stpclk_freq_seq_chk.sv
// Checker for the stop-clock sequencer, bound to the top module.
// Relates the divider state, the gate and the settle count to the handshake.
module stpclk_freq_seq_chk #(
    parameter int DIV_W      = 4,
    parameter int SETTLE_CYC = 8,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_n,
    input logic             pclk,
    input logic [DIV_W-1:0] div_cur,
    input logic             gate_cur,
    input logic [CNT_W-1:0] settle_cnt,
    input logic             err,
    input logic             done,
    input logic             busy
);
    // Divider only changes while the stop request is active.
    assert_div_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_cur) |-> !$past(stop_n));

    // Divider only changes at the end of a low phase of pclk.
    assert_low_phase_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_cur) |-> !$past(pclk));

    // Gated clock stays low.
    assert_gated_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cur |-> !pclk);

    // Release only after the settle count has been reached.
    assert_release_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_n) |-> ($past(settle_cnt) >= CNT_W'(SETTLE_CYC)));

    // Timeout keeps the stop request asserted.
    assert_err_holds_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !stop_n);

    // Done is reported only once idle with the request released.
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && stop_n));
endmodule

bind stpclk_freq_seq stpclk_freq_seq_chk #(
    .DIV_W(DIV_W), .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
) chk_i (
    .clk(clk_ref), .rst_n(rst_n), .stop_n(stop_n), .pclk(pclk),
    .div_cur(div_cur), .gate_cur(gate_cur), .settle_cnt(settle_cnt),
    .err(err), .done(done), .busy(busy)
);

// File: tb/stpclk_freq_seq_tb_top.sv
// Scoreboard bench: the driver queues the expected divider for each command.
// The monitor measures pclk periods and checks each release of stop_n.
module stpclk_freq_seq_tb_top;
    localparam int DIV_W   = 4;
    localparam int DIV_RST = 2;
    localparam int TMO_CYC = 64;
    localparam int GAP_LEN = 1 << DIV_W;

    typedef struct { int div; bit sleep; } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_set_div = 1'b0;
    logic [DIV_W-1:0] cmd_div = '0;
    logic             cmd_sleep = 1'b0;
    logic             wake_req = 1'b0;
    logic             grant_ack = 1'b0;
    logic             pclk, stop_n, busy, done, err;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    exp_t exp_q[$];
    int  drv_div = DIV_RST;
    int  exp_div = DIV_RST;
    int  cyc = 0, last_rise = 0, last_per = 0, settle = 0, rises = 0;
    int  low_len = 0, done_cnt = 0, viol = 0, grant_dly = 4, gcnt = 0;
    bit  have_prev = 0, gap_seen = 0, low_seen = 0, pclk_prev = 0, stop_prev = 1;
    bit  grant_en = 1;

    always #4 clk = ~clk;

    stpclk_freq_seq #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .TMO_CYC(TMO_CYC)) dut_i (
        .clk_ref(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_set_div(cmd_set_div), .cmd_div(cmd_div), .cmd_sleep(cmd_sleep),
        .wake_req(wake_req), .grant_ack(grant_ack), .pclk(pclk),
        .stop_n(stop_n), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Driver: queue the expected divider, then strobe the command.
    task automatic issue(input bit set_div, input int div, input bit slp);
        exp_t e;
        if (set_div) drv_div = (div == 0) ? 1 : div;
        e.div = drv_div;
        e.sleep = slp;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_set_div = set_div; cmd_div = DIV_W'(div); cmd_sleep = slp;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_set_div = 1'b0; cmd_sleep = 1'b0;
    endtask

    task automatic wait_done(input int n);
        for (int i = 0; i < 6000 && done_cnt < n; i++) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Processor model: grants after a delay while stop_n is low.
    initial begin
        forever begin
            @(negedge clk);
            if (!stop_n && rst_n) begin
                if (grant_en && gcnt >= grant_dly) grant_ack = 1'b1;
                else gcnt++;
            end else begin
                grant_ack = 1'b0;
                gcnt = 0;
            end
        end
    end

    // Monitor: period measurement, settle counting and scoreboard at release.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (done) done_cnt++;
                if (!stop_n) low_seen = 1;
                if (pclk && !pclk_prev) begin
                    if (have_prev) begin
                        int per;
                        per = cyc - last_rise;
                        if (gap_seen) settle = 0;
                        else if (per != last_per) settle = 1;
                        else settle++;
                        // R2: no period change while the request is released
                        if (!low_seen && per != 2 * exp_div) begin
                            viol++;
                            $display("FAIL R2: actual %0d expected %0d", per, 2 * exp_div);
                        end
                        last_per = per;
                    end
                    have_prev = 1; last_rise = cyc; low_seen = !stop_n; gap_seen = 0;
                    rises++;
                end
                if (!pclk) low_len++; else low_len = 0;
                if (low_len > GAP_LEN) gap_seen = 1;
                if (stop_n && !stop_prev) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R4 unexpected release", 0, 1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(last_per == 2 * e.div, "R4 new period", last_per, 2 * e.div);
                        if (e.sleep) chk(settle >= 8, "R9 wake settle periods", settle, 8);
                        else chk(settle >= 8, "R5 retune settle periods", settle, 8);
                        exp_div = e.div;
                    end
                end
                pclk_prev = pclk;
                stop_prev = stop_n;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        idle_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stop_n && !busy && !done && !err, "R1 reset outputs",
            {stop_n, busy, done, err}, 4'b1000);
        idle_cycles(30);
        chk(last_per == 2 * DIV_RST, "R1 reset period", last_per, 2 * DIV_RST);

        // R3: stop request first, period held until the delayed grant.
        grant_dly = 40;
        issue(1, 5, 0);
        @(negedge clk);
        chk(!stop_n, "R3 stop request asserted", stop_n, 0);
        idle_cycles(30);
        chk(last_per == 2 * DIV_RST, "R3 period held before grant", last_per, 2 * DIV_RST);
        wait_done(1);
        grant_dly = 4;
        @(negedge clk);
        chk(done_cnt == 1 && !busy && !grant_ack, "R6 done after grant drop", done_cnt, 1);

        // R7: second command lands mid-sequence and is served afterwards.
        issue(1, 0, 0);
        idle_cycles(6);
        issue(1, 7, 0);
        wait_done(3);
        idle_cycles(20);
        chk(done_cnt == 3 && !busy, "R7 held command served", done_cnt, 3);
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        // R8: retune then sleep.
        issue(1, 4, 1);
        idle_cycles(400);
        n = rises;
        idle_cycles(200);
        chk(rises == n && !pclk, "R8 clock gated", rises - n, 0);
        chk(!stop_n && busy, "R8 stop held in sleep", stop_n, 0);
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        wait_done(4);
        idle_cycles(10);
        chk(done_cnt == 4, "R9 wake completes", done_cnt, 4);

        // R10: wake outside sleep is ignored.
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        idle_cycles(50);
        chk(stop_n && !busy, "R10 stray wake ignored", {stop_n, busy}, 2'b10);

        // R12: empty command is ignored.
        @(negedge clk); cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        idle_cycles(30);
        chk(stop_n && !busy, "R12 empty command ignored", {stop_n, busy}, 2'b10);

        // R11: grant withheld until the timeout.
        grant_en = 0;
        issue(1, 6, 0);
        idle_cycles(TMO_CYC + 10);
        chk(err, "R11 timeout flag", err, 1);
        chk(!stop_n, "R11 stop held on timeout", stop_n, 0);
        chk(last_per == 8, "R11 period unchanged on timeout", last_per, 8);
        grant_en = 1;
        idle_cycles(10);
        chk(!err, "R11 flag clears on grant", err, 0);
        wait_done(5);
        idle_cycles(40);
        chk(done_cnt == 5 && !busy, "R11 sequence completes", done_cnt, 5);
        chk(last_per == 12, "R2 final period", last_per, 12);
        chk(viol == 0, "R2 no period change while released", viol, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule